// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Bank

This block holds the host-visible interrupt and status state of a memory-mapped flash controller. The command execution engine reports each finished operation (load, program, erase or warm reset) as a single-cycle event with a pass/fail flag. The bank turns these events into sticky done and error bits, drives a host interrupt pin of selectable polarity and a ready pin, and holds two configuration words and the last accepted command word.

The host reaches the bank through a 16-bit register port: a write strobe with address and data, and a separate combinational read address and data pair. A command write is handed to the execution engine as a one-cycle `cmd_issue` pulse, but only while no earlier completion is still pending. The host acknowledges a completion by writing a mask into the interrupt status word. When that acknowledge leaves the master bit clear, the error bits are wiped with it. Completion events have no back-pressure: the bank takes an event in every cycle in which `op_valid` is high.

Top module: `flash_irq_status_bank`

## Requirements
- R1: Register map on `wr_addr`/`rd_addr`: 0 interrupt status, 1 error status (host writes have no effect), 2 configuration A (reads back AND 0xFFE0), 3 configuration B, 4 command (reads the last accepted command word), 5 ECC result (always reads 0). Unmapped addresses read 0. Reads are combinational. Writes take effect at the next rising clock edge.
- R2: A synchronous active-high `rst` sets interrupt status to 0x8080, error status to 0, configuration A to 0x40C0, configuration B to 0 and command to 0.
- R3: An event with `op_valid` high sets interrupt status bit 15 (master) together with the done bit of its kind, visible from the next cycle. The `op_kind` encodings are 0 load (bit 7), 1 program (bit 6) and 2 erase (bit 5).
- R4: An event of kind 0, 1 or 2 with `op_fail` high also sets error bit 10 (command error) plus the error bit of its kind: load bit 13, program bit 12, erase bit 11.
- R5: A host write to interrupt status ANDs the written data into the current value. A 0 clears the bit and a 1 keeps it.
- R6: When an interrupt status write leaves bit 15 clear, error bits 10 to 13 are cleared in the same edge. Otherwise the error status is unchanged.
- R7: A command write while interrupt status bit 15 is set is refused: the command register keeps its value and no `cmd_issue` pulse appears. An accepted write raises `cmd_issue` for exactly the cycle after the write, with `cmd_word` holding the written value.
- R8: `irq_o` equals interrupt status bit 15 XOR the inverse of configuration A bit 6. `ready_o` equals configuration A bit 7.
- R9: An event of `op_kind` 3 is a warm reset. It sets interrupt status to 0x8010 and loads every other register with its R2 value. `op_fail` is ignored, and the warm reset wins over any host write in the same cycle.
- R10: When an event and an interrupt status write fall in the same cycle, the event's set bits win over the write's clears. Error bits raised by the event survive the error wipe of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high cold reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 16 | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 16 | Combinational read data |
| op_valid | input | 1 | One-cycle completion event from the execution engine |
| op_kind | input | 2 | Event kind: 0 load, 1 program, 2 erase, 3 warm reset |
| op_fail | input | 1 | Event reports a failed operation |
| cmd_issue | output | 1 | One-cycle pulse for an accepted command |
| cmd_word | output | 16 | Last accepted command word |
| irq_o | output | 1 | Host interrupt with selectable polarity |
| ready_o | output | 1 | Ready level from configuration A bit 7 |

## Verification
A wrong master bit shows one cycle later in three places: the `irq_o` level, the interrupt status read, and whether the next command write produces `cmd_issue`. A corrupted error word shows only through the read port. It becomes visible after the acknowledge write that should have wiped it, or after an event that should have set it. The set-over-clear and warm-reset priorities matter only when events and host writes share a cycle, so the bench drives those collisions directly and reads the registers in the cycle that follows.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

  localparam int REG_W = 16;

  // Interrupt status bit positions
  localparam int IB_MASTER = 15;
  localparam int IB_LOAD   = 7;
  localparam int IB_PROG   = 6;
  localparam int IB_ERASE  = 5;
  localparam int IB_RESET  = 4;

  // Error status bit positions
  localparam int EB_CMD   = 10;
  localparam int EB_ERASE = 11;
  localparam int EB_PROG  = 12;
  localparam int EB_LOAD  = 13;

  localparam logic [REG_W-1:0] ERR_ALL_MASK  = 16'h3C00;
  localparam logic [REG_W-1:0] INT_COLD_VAL  = 16'h8080;
  localparam logic [REG_W-1:0] INT_WARM_VAL  = 16'h8010;
  localparam logic [REG_W-1:0] CFGA_RST_VAL  = 16'h40C0;
  localparam logic [REG_W-1:0] CFGA_RD_MASK  = 16'hFFE0;

  // Configuration A control bits
  localparam int CB_POLARITY = 6;
  localparam int CB_READY    = 7;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } op_kind_e;

  // Register addresses
  localparam int RA_INTR  = 0;
  localparam int RA_ERRS  = 1;
  localparam int RA_CFG_A = 2;
  localparam int RA_CFG_B = 3;
  localparam int RA_CMD   = 4;
  localparam int RA_ECC   = 5;

endpackage

// File: rtl/flash_irq_event_decode.sv
module flash_irq_event_decode
  import flash_irq_pkg::*;
(
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic             op_fail,
  output logic [REG_W-1:0] int_set,
  output logic [REG_W-1:0] err_set,
  output logic             warm_rst
);

  logic [REG_W-1:0] done_bit;
  logic [REG_W-1:0] kind_err_bit;

  // Per-kind bit lookup
  always_comb begin
    done_bit     = '0;
    kind_err_bit = '0;
    unique case (op_kind_e'(op_kind))
      OP_LOAD: begin
        done_bit[IB_LOAD]      = 1'b1;
        kind_err_bit[EB_LOAD]  = 1'b1;
      end
      OP_PROG: begin
        done_bit[IB_PROG]      = 1'b1;
        kind_err_bit[EB_PROG]  = 1'b1;
      end
      OP_ERASE: begin
        done_bit[IB_ERASE]     = 1'b1;
        kind_err_bit[EB_ERASE] = 1'b1;
      end
      default: begin
        done_bit[IB_RESET]     = 1'b1;
      end
    endcase
  end

  always_comb begin
    int_set  = '0;
    err_set  = '0;
    warm_rst = 1'b0;
    if (op_valid) begin
      if (op_kind_e'(op_kind) == OP_RESET) begin
        warm_rst = 1'b1;
      end else begin
        int_set            = done_bit;
        int_set[IB_MASTER] = 1'b1;
        if (op_fail) begin
          err_set         = kind_err_bit;
          err_set[EB_CMD] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/flash_irq_status_regs.sv
module flash_irq_status_regs
  import flash_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             warm_rst,
  input  logic             int_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] int_set,
  input  logic [REG_W-1:0] err_set,
  output logic [REG_W-1:0] int_q,
  output logic [REG_W-1:0] err_q
);

  logic [REG_W-1:0] int_after_wr;
  logic [REG_W-1:0] err_after_wr;
  logic [REG_W-1:0] int_nx;
  logic [REG_W-1:0] err_nx;

  // Host acknowledge is applied first, event sets are ORed on top
  always_comb begin
    int_after_wr = int_wr ? (int_q & wdata) : int_q;
    err_after_wr = err_q;
    if (int_wr && !int_after_wr[IB_MASTER]) begin
      err_after_wr = err_q & ~ERR_ALL_MASK;
    end
    int_nx = int_after_wr | int_set;
    err_nx = err_after_wr | err_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= INT_COLD_VAL;
      err_q <= '0;
    end else if (warm_rst) begin
      int_q <= INT_WARM_VAL;
      err_q <= '0;
    end else begin
      int_q <= int_nx;
      err_q <= err_nx;
    end
  end

endmodule

// File: rtl/flash_irq_config_regs.sv
module flash_irq_config_regs
  import flash_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             warm_rst,
  input  logic             cfg_a_wr,
  input  logic             cfg_b_wr,
  input  logic             cmd_wr,
  input  logic             busy,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cfg_a_q,
  output logic [REG_W-1:0] cfg_b_q,
  output logic [REG_W-1:0] cmd_q,
  output logic             cmd_issue
);

  logic cmd_accept;

  assign cmd_accept = cmd_wr && !busy;

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      cfg_a_q   <= CFGA_RST_VAL;
      cfg_b_q   <= '0;
      cmd_q     <= '0;
      cmd_issue <= 1'b0;
    end else begin
      cmd_issue <= cmd_accept;
      if (cfg_a_wr)   cfg_a_q <= wdata & CFGA_RD_MASK;
      if (cfg_b_wr)   cfg_b_q <= wdata;
      if (cmd_accept) cmd_q   <= wdata;
    end
  end

endmodule

// File: rtl/flash_irq_read_mux.sv
module flash_irq_read_mux
  import flash_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  int_q,
  input  logic [REG_W-1:0]  err_q,
  input  logic [REG_W-1:0]  cfg_a_q,
  input  logic [REG_W-1:0]  cfg_b_q,
  input  logic [REG_W-1:0]  cmd_q,
  output logic [REG_W-1:0]  rd_data
);

  always_comb begin
    rd_data = '0;
    if      (rd_addr == ADDR_W'(RA_INTR))  rd_data = int_q;
    else if (rd_addr == ADDR_W'(RA_ERRS))  rd_data = err_q;
    else if (rd_addr == ADDR_W'(RA_CFG_A)) rd_data = cfg_a_q & CFGA_RD_MASK;
    else if (rd_addr == ADDR_W'(RA_CFG_B)) rd_data = cfg_b_q;
    else if (rd_addr == ADDR_W'(RA_CMD))   rd_data = cmd_q;
    else if (rd_addr == ADDR_W'(RA_ECC))   rd_data = '0;
  end

endmodule

// File: rtl/flash_irq_status_bank.sv
module flash_irq_status_bank
  import flash_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_fail,
  output logic              cmd_issue,
  output logic [15:0]       cmd_word,
  output logic              irq_o,
  output logic              ready_o
);

  logic [REG_W-1:0] int_set, err_set;
  logic             warm_rst;
  logic [REG_W-1:0] int_q, err_q;
  logic [REG_W-1:0] cfg_a_q, cfg_b_q, cmd_q;
  logic             wr_intr, wr_cfg_a, wr_cfg_b, wr_cmd;

  // Write address decode
  assign wr_intr  = wr_en && (wr_addr == ADDR_W'(RA_INTR));
  assign wr_cfg_a = wr_en && (wr_addr == ADDR_W'(RA_CFG_A));
  assign wr_cfg_b = wr_en && (wr_addr == ADDR_W'(RA_CFG_B));
  assign wr_cmd   = wr_en && (wr_addr == ADDR_W'(RA_CMD));

  flash_irq_event_decode u_evt (
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_fail  (op_fail),
    .int_set  (int_set),
    .err_set  (err_set),
    .warm_rst (warm_rst)
  );

  flash_irq_status_regs u_stat (
    .clk      (clk),
    .rst      (rst),
    .warm_rst (warm_rst),
    .int_wr   (wr_intr),
    .wdata    (wr_data),
    .int_set  (int_set),
    .err_set  (err_set),
    .int_q    (int_q),
    .err_q    (err_q)
  );

  flash_irq_config_regs u_cfg (
    .clk       (clk),
    .rst       (rst),
    .warm_rst  (warm_rst),
    .cfg_a_wr  (wr_cfg_a),
    .cfg_b_wr  (wr_cfg_b),
    .cmd_wr    (wr_cmd),
    .busy      (int_q[IB_MASTER]),
    .wdata     (wr_data),
    .cfg_a_q   (cfg_a_q),
    .cfg_b_q   (cfg_b_q),
    .cmd_q     (cmd_q),
    .cmd_issue (cmd_issue)
  );

  flash_irq_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .rd_addr (rd_addr),
    .int_q   (int_q),
    .err_q   (err_q),
    .cfg_a_q (cfg_a_q),
    .cfg_b_q (cfg_b_q),
    .cmd_q   (cmd_q),
    .rd_data (rd_data)
  );

  assign cmd_word = cmd_q;
  assign irq_o    = int_q[IB_MASTER] ^ ~cfg_a_q[CB_POLARITY];
  assign ready_o  = cfg_a_q[CB_READY];

endmodule

// File: rtl/flash_irq_status_bank_chk.sv
module flash_irq_status_bank_chk
  import flash_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic              op_fail,
  input logic              cmd_issue,
  input logic [15:0]       int_q,
  input logic [15:0]       err_q
);

  logic wr_intr_c, wr_cmd_c;
  assign wr_intr_c = wr_en && (wr_addr == ADDR_W'(RA_INTR));
  assign wr_cmd_c  = wr_en && (wr_addr == ADDR_W'(RA_CMD));

  assert_cmd_refused_R7: assert property (@(posedge clk) disable iff (rst)
    wr_cmd_c && int_q[IB_MASTER] |=> !cmd_issue);

  assert_load_done_R3: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_kind == 2'd0 |=> int_q[IB_MASTER] && int_q[IB_LOAD]);

  assert_prog_done_R3: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_kind == 2'd1 |=> int_q[IB_MASTER] && int_q[IB_PROG]);

  assert_erase_done_R3: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_kind == 2'd2 |=> int_q[IB_MASTER] && int_q[IB_ERASE]);

  assert_fail_flags_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_fail && op_kind != 2'd3 |=> err_q[EB_CMD]);

  assert_and_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_intr_c && !op_valid |=> int_q == ($past(int_q) & $past(wr_data)));

  assert_err_wipe_R6: assert property (@(posedge clk) disable iff (rst)
    wr_intr_c && !op_valid && !(int_q[IB_MASTER] && wr_data[IB_MASTER])
    |=> err_q[13:10] == 4'd0);

  assert_warm_reset_R9: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_kind == 2'd3 |=> int_q == INT_WARM_VAL && err_q == 16'd0);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_kind != 2'd3 && wr_intr_c |=> int_q[IB_MASTER]);

endmodule

bind flash_irq_status_bank flash_irq_status_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .op_fail   (op_fail),
  .cmd_issue (cmd_issue),
  .int_q     (int_q),
  .err_q     (err_q)
);

// File: tb/flash_irq_status_bank_tb.sv
module flash_irq_status_bank_tb;

  localparam int AW = 3;
  localparam int SEL_IRQ   = 8;
  localparam int SEL_READY = 9;
  localparam int SEL_ISSUE = 10;
  localparam int SEL_CMDW  = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = '0;
  logic          op_fail = 1'b0;
  logic          cmd_issue;
  logic [15:0]   cmd_word;
  logic          irq_o;
  logic          ready_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #5 clk = ~clk;

  flash_irq_status_bank #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .op_valid(op_valid), .op_kind(op_kind),
    .op_fail(op_fail), .cmd_issue(cmd_issue), .cmd_word(cmd_word),
    .irq_o(irq_o), .ready_o(ready_o)
  );

  // Monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      if (it.sel < 8) rd_addr = AW'(it.sel);
      #1;
      case (it.sel)
        SEL_IRQ:   act = {15'd0, irq_o};
        SEL_READY: act = {15'd0, ready_o};
        SEL_ISSUE: act = {15'd0, cmd_issue};
        SEL_CMDW:  act = cmd_word;
        default:   act = rd_data;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input logic [15:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic op(input logic [1:0] k, input logic f);
    @(posedge clk); #1;
    op_valid = 1'b1; op_kind = k; op_fail = f;
    @(posedge clk); #1;
    op_valid = 1'b0; op_fail = 1'b0;
  endtask

  task automatic wr_op(input int a, input logic [15:0] d, input logic [1:0] k, input logic f);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    op_valid = 1'b1; op_kind = k; op_fail = f;
    @(posedge clk); #1;
    wr_en = 1'b0; op_valid = 1'b0; op_fail = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R2 / R1: cold reset values and fixed ECC read
    expect_val(0, 16'h8080, "R2 intr cold");
    expect_val(1, 16'h0000, "R2 errs cold");
    expect_val(2, 16'h40C0, "R2 cfgA cold");
    expect_val(3, 16'h0000, "R2 cfgB cold");
    expect_val(4, 16'h0000, "R2 cmd cold");
    expect_val(5, 16'h0000, "R1 ecc zero");
    expect_val(SEL_IRQ, 16'h1, "R8 irq at reset");
    expect_val(SEL_READY, 16'h1, "R8 ready at reset");

    // R7: command refused while master bit pending
    wr(4, 16'h0011);
    expect_val(SEL_ISSUE, 16'h0, "R7 refused no pulse");
    expect_val(4, 16'h0000, "R7 refused cmd kept");

    // R5: acknowledge all
    wr(0, 16'h0000);
    expect_val(0, 16'h0000, "R5 clear all");
    expect_val(SEL_IRQ, 16'h0, "R8 irq low after ack");

    // R7: accepted command
    wr(4, 16'h0094);
    expect_val(SEL_ISSUE, 16'h1, "R7 accepted pulse");
    expect_val(SEL_ISSUE, 16'h0, "R7 pulse one cycle");
    expect_val(SEL_CMDW, 16'h0094, "R7 cmd_word");

    // R3: erase success
    op(2'd2, 1'b0);
    expect_val(0, 16'h8020, "R3 erase done");
    expect_val(1, 16'h0000, "R4 no error on pass");
    expect_val(SEL_IRQ, 16'h1, "R8 irq on event");

    // R5: AND keeps bit 5
    wr(0, 16'h7FFF);
    expect_val(0, 16'h0020, "R5 and-mask");

    // R4: program fail
    op(2'd1, 1'b1);
    expect_val(0, 16'h8060, "R3 prog done");
    expect_val(1, 16'h1400, "R4 prog error");

    // R6: write keeping master leaves errors
    wr(0, 16'hFFFF);
    expect_val(0, 16'h8060, "R5 all-ones no change");
    expect_val(1, 16'h1400, "R6 errors kept");
    wr(0, 16'h7FFF);
    expect_val(0, 16'h0060, "R5 master cleared");
    expect_val(1, 16'h0000, "R6 errors wiped");

    // R10: load fail collides with clear-all write
    wr_op(0, 16'h0000, 2'd0, 1'b1);
    expect_val(0, 16'h8080, "R10 set over clear");
    expect_val(1, 16'h2400, "R10 load error survives");

    // R1 / R8: config A mask and polarity
    wr(2, 16'h009F);
    expect_val(2, 16'h0080, "R1 cfgA read mask");
    expect_val(SEL_IRQ, 16'h0, "R8 inverted polarity");
    expect_val(SEL_READY, 16'h1, "R8 ready bit7");
    wr(0, 16'h0000);
    expect_val(SEL_IRQ, 16'h1, "R8 inverted idle high");
    expect_val(1, 16'h0000, "R6 wipe after ack");
    wr(2, 16'h0000);
    expect_val(SEL_READY, 16'h0, "R8 ready low");
    wr(3, 16'h1234);
    expect_val(3, 16'h1234, "R1 cfgB write");
    wr(1, 16'hFFFF);
    expect_val(1, 16'h0000, "R1 errs write ignored");

    // R4: erase fail
    op(2'd2, 1'b1);
    expect_val(0, 16'h8020, "R3 erase done again");
    expect_val(1, 16'h0C00, "R4 erase error");

    // R9: warm reset beats same-cycle write
    wr_op(3, 16'h5555, 2'd3, 1'b1);
    expect_val(0, 16'h8010, "R9 warm intr");
    expect_val(1, 16'h0000, "R9 warm errs");
    expect_val(2, 16'h40C0, "R9 warm cfgA");
    expect_val(3, 16'h0000, "R9 warm cfgB over write");
    expect_val(4, 16'h0000, "R9 warm cmd");
    expect_val(SEL_IRQ, 16'h1, "R9 irq after warm");
    expect_val(SEL_READY, 16'h1, "R9 ready after warm");

    // R7 / R3: command accepted in the cycle a load completes
    wr(0, 16'h0000);
    wr_op(4, 16'h0027, 2'd0, 1'b0);
    expect_val(SEL_ISSUE, 16'h1, "R7 accept with event");
    expect_val(0, 16'h8080, "R3 load done");
    expect_val(1, 16'h0000, "R4 load pass no error");
    wr(4, 16'h00AA);
    expect_val(SEL_ISSUE, 16'h0, "R7 refused again");
    expect_val(4, 16'h0027, "R7 cmd retained");

    done = 1'b1;
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule